// File: doc/BRIEF.md
# PWM Duty Fade Engine

A single pulse-width-modulated output whose duty cycle can be ramped by hardware instead of being rewritten period by period by software. A free-running counter defines the PWM period, and the output is high while the counter is below the duty currently in force. Software writes a starting duty, then writes one configuration word. That word holds the step amount, the number of periods between steps, the number of steps and the direction, plus a start bit that arms the ramp.

Once armed, the engine walks the duty up or down by the step amount at each interval. The duty clamps at the ends of its range instead of wrapping. The engine stops after the requested number of steps and raises a done flag. Every duty change, whether written by software or produced by the ramp, is applied only at a period boundary, so no pulse is ever cut short or stretched in the middle of a period.

Top module: `pwm_fade_engine`

## Requirements
- R1: After reset the duty in force is 0, the period counter is 0, `pwm_out` is low and `fade_done` is low.
- R2: The PWM period is 2^DUTY_W clock cycles. Within each period `pwm_out` is high in exactly those cycles where the period counter (0 .. 2^DUTY_W-1) is below the duty in force.
- R3: A duty write (`wr_sel`=0, value in `wr_data[DUTY_W-1:0]`) and every ramp step change the duty in force only at the next period boundary. The period in progress keeps its old duty.
- R4: A configuration write (`wr_sel`=1) with bit 31 clear stores the settings but has no effect on the output or on `fade_done`.
- R5: Configuration word layout: step amount in bits 9:0, interval in bits 19:10, step count in bits 29:20, direction in bit 30, start in bit 31. The start bit is a self-clearing one-cycle request, and the engine takes the stored settings on it. The direction resets to 1.
- R6: While a ramp runs, the duty changes once every interval periods, counted from the first period boundary after the start. An interval of 0 behaves as 1.
- R7: Direction 1 adds the step amount to the duty. Direction 0 subtracts it.
- R8: The duty saturates at 2^DUTY_W-1 when rising and at 0 when falling. It never wraps.
- R9: `fade_done` rises once the last of the requested steps has been applied, and the duty then stays fixed. A step count of 0 raises `fade_done` two cycles after the write and leaves the duty unchanged.
- R10: A start with a non-zero step count clears `fade_done` until that ramp completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | 1 | 0 selects the duty register, 1 selects the fade configuration word |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | PWM output |
| fade_done | output | 1 | High once the requested ramp has completed |

## Verification
The duty is measured at the output by counting high cycles over each period. This is done first for static duties, including a write landing mid-period to show the old duty finishing its period. A configuration write without the start bit is shown to change neither the output nor the flag. Ramps are run rising with an interval of two, which separates the step spacing from the step size. They are also run falling with an interval of zero, which shows the zero-as-one rule and the clamp at 0, and rising with a step larger than full scale, which shows the clamp at the top. A restart, a zero step count and the timing of the done flag relative to the last applied step complete the set.

// File: rtl/pwm_fade_pkg.sv
package pwm_fade_pkg;

    localparam int FLD_W     = 10;
    localparam int STEP_LSB  = 0;
    localparam int GAP_LSB   = 10;
    localparam int TOTAL_LSB = 20;
    localparam int DIR_BIT   = 30;
    localparam int START_BIT = 31;

    typedef struct packed {
        logic [FLD_W-1:0] step_amt;
        logic [FLD_W-1:0] step_gap;
        logic [FLD_W-1:0] step_total;
        logic             raise;
    } fade_cfg_t;

    localparam fade_cfg_t CFG_RESET = '{step_amt: '0, step_gap: '0, step_total: '0, raise: 1'b1};

endpackage

// File: rtl/fade_cfg_regs.sv
module fade_cfg_regs
    import pwm_fade_pkg::*;
#(
    parameter int DUTY_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    output fade_cfg_t         cfg_o,
    output logic              start_o,
    output logic              duty_wr_o,
    output logic [DUTY_W-1:0] duty_wdata_o
);

    typedef struct packed {
        fade_cfg_t cfg;
        logic      start;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic cfg_write;
    assign cfg_write = wr_en && wr_sel;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (cfg_write) begin
            st_d.cfg.step_amt   = wr_data[STEP_LSB  +: FLD_W];
            st_d.cfg.step_gap   = wr_data[GAP_LSB   +: FLD_W];
            st_d.cfg.step_total = wr_data[TOTAL_LSB +: FLD_W];
            st_d.cfg.raise      = wr_data[DIR_BIT];
            st_d.start          = wr_data[START_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RESET;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o        = st_q.cfg;
    assign start_o      = st_q.start;
    assign duty_wr_o    = wr_en && !wr_sel;
    assign duty_wdata_o = wr_data[DUTY_W-1:0];

    // R5: start request lasts one cycle unless a new start write arrives
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start && !(cfg_write && wr_data[START_BIT])) |=> !st_q.start);

    // R4: a configuration write without the start bit never arms the ramp
    p_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_write && !wr_data[START_BIT]) |=> !st_q.start);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int DUTY_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              wrap_o
);

    localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == CNT_MAX);

    // R2: the period restarts at zero after its last cycle
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

    // R2: inside a period the counter advances by one each cycle
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/fade_stepper.sv
module fade_stepper
    import pwm_fade_pkg::*;
#(
    parameter int DUTY_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              start_i,
    input  fade_cfg_t         cfg_i,
    input  logic              duty_wr_i,
    input  logic [DUTY_W-1:0] duty_wdata_i,
    output logic [DUTY_W-1:0] duty_act_o,
    output logic              done_o
);

    localparam int SUM_W = ((DUTY_W > FLD_W) ? DUTY_W : FLD_W) + 1;
    localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};
    localparam logic [SUM_W-1:0]  DUTY_MAX_W = SUM_W'(DUTY_MAX);

    typedef struct packed {
        logic [DUTY_W-1:0] duty_work;
        logic [DUTY_W-1:0] duty_act;
        logic [FLD_W-1:0]  gap_cnt;
        logic [FLD_W-1:0]  gap_lim;
        logic [FLD_W-1:0]  steps_left;
        logic [FLD_W-1:0]  step_amt;
        logic              raise;
        logic              active;
        logic              done;
    } step_state_t;

    step_state_t q, d;

    logic              gap_reached;
    logic              step_fire;
    logic [SUM_W-1:0]  work_w;
    logic [SUM_W-1:0]  amt_w;
    logic [SUM_W-1:0]  sum_w;
    logic [DUTY_W-1:0] stepped;

    always_comb begin
        work_w      = SUM_W'(q.duty_work);
        amt_w       = SUM_W'(q.step_amt);
        sum_w       = work_w + amt_w;
        gap_reached = ((q.gap_cnt + 1'b1) == q.gap_lim);
        step_fire   = boundary_i && q.active && gap_reached;

        if (q.raise) begin
            stepped = (sum_w > DUTY_MAX_W) ? DUTY_MAX : sum_w[DUTY_W-1:0];
        end else begin
            stepped = (amt_w >= work_w) ? '0 : DUTY_W'(work_w - amt_w);
        end
    end

    always_comb begin
        d = q;

        if (step_fire) begin
            d.duty_work  = stepped;
            d.gap_cnt    = '0;
            d.steps_left = q.steps_left - 1'b1;
            if (q.steps_left == FLD_W'(1)) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end else if (boundary_i && q.active) begin
            d.gap_cnt = q.gap_cnt + 1'b1;
        end

        if (duty_wr_i) begin
            d.duty_work = duty_wdata_i;
        end

        if (start_i) begin
            d.step_amt   = cfg_i.step_amt;
            d.gap_lim    = (cfg_i.step_gap == '0) ? FLD_W'(1) : cfg_i.step_gap;
            d.steps_left = cfg_i.step_total;
            d.raise      = cfg_i.raise;
            d.gap_cnt    = '0;
            if (cfg_i.step_total == '0) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end else begin
                d.active = 1'b1;
                d.done   = 1'b0;
            end
        end

        if (boundary_i) begin
            d.duty_act = d.duty_work;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q            <= '0;
            q.gap_lim    <= FLD_W'(1);
            q.raise      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign duty_act_o = q.duty_act;
    assign done_o     = q.done;

    // R3: the duty in force changes only across a period boundary
    p_act_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> $stable(q.duty_act));

    // R7: a rising step never lowers the duty
    p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && q.raise && !duty_wr_i && !start_i) |=> (q.duty_work >= $past(q.duty_work)));

    // R7: a falling step never raises the duty
    p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && !q.raise && !duty_wr_i && !start_i) |=> (q.duty_work <= $past(q.duty_work)));

    // R8: full scale stays at full scale on a rising step
    p_sat_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && q.raise && !duty_wr_i && (q.duty_work == DUTY_MAX)) |=> (q.duty_work == DUTY_MAX));

    // R9: the last step completes the ramp
    p_last_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire && (q.steps_left == FLD_W'(1)) && !start_i) |=> (q.done && !q.active));

    // R9: a zero step count finishes at once without touching the duty
    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (cfg_i.step_total == '0) && !duty_wr_i) |=> (q.done && $stable(q.duty_work)));

    // R10: a start with steps to take clears the done flag
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (cfg_i.step_total != '0)) |=> !q.done);

endmodule

// File: rtl/pwm_fade_engine.sv
module pwm_fade_engine
    import pwm_fade_pkg::*;
#(
    parameter int DUTY_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic        pwm_out,
    output logic        fade_done
);

    fade_cfg_t         cfg;
    logic              start;
    logic              duty_wr;
    logic [DUTY_W-1:0] duty_wdata;
    logic [DUTY_W-1:0] cnt;
    logic              wrap;
    logic [DUTY_W-1:0] duty_act;

    fade_cfg_regs #(.DUTY_W(DUTY_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .cfg_o        (cfg),
        .start_o      (start),
        .duty_wr_o    (duty_wr),
        .duty_wdata_o (duty_wdata)
    );

    pwm_period_ctr #(.DUTY_W(DUTY_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    fade_stepper #(.DUTY_W(DUTY_W)) u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (wrap),
        .start_i      (start),
        .cfg_i        (cfg),
        .duty_wr_i    (duty_wr),
        .duty_wdata_i (duty_wdata),
        .duty_act_o   (duty_act),
        .done_o       (fade_done)
    );

    assign pwm_out = (cnt < duty_act);

    // R2: a zero duty keeps the output low
    p_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_out);

    // R2: the first cycle of a period is high whenever the duty is non-zero
    p_first_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '0) && (duty_act != '0)) |-> pwm_out);

endmodule

// File: tb/pwm_fade_engine_tb.sv
module pwm_fade_engine_tb;

    localparam int W      = 6;
    localparam int PERIOD = 1 << W;
    localparam int FULL   = PERIOD - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pwm_out;
    logic        fade_done;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] ph;

    always #4 clk = ~clk;

    pwm_fade_engine #(.DUTY_W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out),
        .fade_done (fade_done)
    );

    // bench's own period phase, from reset timing
    always @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + 1'b1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ph(input int v);
        while (int'(ph) != v) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] cfg_word(input int amt, input int gap, input int total,
                                             input bit raise, input bit go);
        logic [31:0] w;
        w = '0;
        w[9:0]   = amt[9:0];
        w[19:10] = gap[9:0];
        w[29:20] = total[9:0];
        w[30]    = raise;
        w[31]    = go;
        return w;
    endfunction

    task automatic measure(output int highs);
        wait_ph(0);
        highs = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int h;
        check("R1", "fade_done after reset", int'(fade_done), 0);
        measure(h);
        check("R1", "high cycles after reset", h, 0);
    endtask

    task automatic t_static();
        int h;
        wr(1'b0, 32'd10);
        measure(h);
        measure(h);
        check("R2", "static duty 10", h, 10);
        wr(1'b0, 32'd45);
        measure(h);
        measure(h);
        check("R2", "static duty 45", h, 45);
    endtask

    task automatic t_boundary();
        int h;
        wait_ph(0);
        wr(1'b0, 32'd20);
        measure(h);
        measure(h);
        check("R3", "duty before mid write", h, 20);
        // write 50 at phase 30 of a period at duty 20
        wait_ph(30);
        wr(1'b0, 32'd50);
        wait_ph(0);
        measure(h);
        check("R3", "period after mid write", h, 50);
        wait_ph(30);
        wr(1'b0, 32'd20);
        wait_ph(0);
    endtask

    task automatic t_boundary_partial();
        int h;
        h = 0;
        wait_ph(0);
        for (int i = 0; i < PERIOD; i++) begin
            if (i == 30) begin
                wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'd60;
            end else begin
                wr_en = 1'b0; wr_data = '0;
            end
            if (pwm_out) h++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R3", "period holding old duty 20", h, 20);
        measure(h);
        check("R3", "next period takes 60", h, 60);
    endtask

    task automatic t_no_start();
        int h;
        wr(1'b1, cfg_word(7, 1, 5, 1'b1, 1'b0));
        for (int p = 0; p < 3; p++) begin
            measure(h);
            check("R4", "duty after config without start", h, 60);
            check("R4", "fade_done after config without start", int'(fade_done), 0);
        end
    endtask

    task automatic t_fade_rise();
        int h;
        int exp_d [8] = '{10, 15, 15, 20, 20, 25, 25, 25};
        wr(1'b0, 32'd10);
        wait_ph(0);
        wr(1'b1, cfg_word(5, 2, 3, 1'b1, 1'b1));
        for (int i = 1; i <= 8; i++) begin
            wait_ph(0);
            check("R9", $sformatf("rise done at start of period %0d", i), int'(fade_done), (i >= 6) ? 1 : 0);
            measure(h);
            check((i <= 6) ? "R6" : "R5", $sformatf("rise duty period %0d", i), h, exp_d[i-1]);
        end
    endtask

    task automatic t_fade_fall();
        int h;
        int exp_d [6] = '{4, 1, 0, 0, 0, 0};
        wr(1'b0, 32'd7);
        wait_ph(0);
        wr(1'b1, cfg_word(3, 0, 4, 1'b0, 1'b1));
        for (int i = 1; i <= 6; i++) begin
            wait_ph(0);
            check("R9", $sformatf("fall done at start of period %0d", i), int'(fade_done), (i >= 4) ? 1 : 0);
            measure(h);
            check((i <= 2) ? "R7" : "R8", $sformatf("fall duty period %0d", i), h, exp_d[i-1]);
        end
    endtask

    task automatic t_sat_top();
        int h;
        wr(1'b0, 32'd60);
        wait_ph(0);
        wr(1'b1, cfg_word(500, 1, 2, 1'b1, 1'b1));
        for (int i = 1; i <= 3; i++) begin
            measure(h);
            check("R8", $sformatf("top clamp period %0d", i), h, FULL);
        end
        check("R9", "done after top clamp ramp", int'(fade_done), 1);
    endtask

    task automatic t_restart();
        int h;
        wr(1'b0, 32'd30);
        wait_ph(0);
        wr(1'b1, cfg_word(1, 5, 3, 1'b1, 1'b1));
        @(negedge clk);
        check("R10", "done cleared by restart", int'(fade_done), 0);
        measure(h);
        check("R10", "duty during slow ramp", h, 30);
    endtask

    task automatic t_zero_count();
        int h;
        wr(1'b0, 32'd33);
        wait_ph(0);
        wr(1'b1, cfg_word(5, 1, 0, 1'b1, 1'b1));
        check("R9", "done one cycle after zero-count write", int'(fade_done), 0);
        @(negedge clk);
        check("R9", "done two cycles after zero-count write", int'(fade_done), 1);
        measure(h);
        measure(h);
        check("R9", "duty unchanged by zero count", h, 33);
        measure(h);
        check("R9", "duty still unchanged", h, 33);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_boundary();
        t_boundary_partial();
        t_no_start();
        t_fade_rise();
        t_fade_fall();
        t_sat_top();
        t_restart();
        t_zero_count();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule